// File: doc/BRIEF.md
# Management-Mode Entry Sequencer

This block moves a simple in-order core into a privileged management mode and back out of it. A management request pulse is held in a sticky pending flag. No enable or mask input can block it, and it outranks every ordinary interrupt line. The switch waits for an instruction boundary, which the core reports on `insn_done_i`. The sequencer then stalls fetch and copies the core's register file, the return program counter and the current base value into a save area. The save area sits in a small protected memory. The sequencer then raises the management flag and redirects the core to the base plus a fixed entry offset.

A resume command reverses the process. The save area is read back slot by slot, each general register is handed to the core through a restore write port, and the base register is reloaded from its own slot. When the readback is done, the core is sent back to the saved program counter and the management flag drops. The protected memory has one access port for handler code and a debug path, and a qualifier decides which accesses are granted. Ordinary accesses are served only in management mode. Debug accesses are also served in normal mode, but only until a sticky lock bit is set.

Top module: `mgmt_entry_seq`

## Requirements
- R1: No input can mask or delay a latched management request except the boundary wait. A request is taken at a boundary even when every bit of `irq_mask_i` is 1.
- R2: At a boundary in normal mode with no management request pending, `irq_ack_o` goes high one cycle later as a one-hot pulse on the lowest index of `irq_req_i & ~irq_mask_i`. When a management request is pending at that boundary, the sequencer enters management mode and `irq_ack_o` stays 0.
- R3: A pending request starts the save sequence only at a cycle where `insn_done_i` is 1. `busy_o` rises on the next cycle. With `insn_done_i` held at 0, nothing starts.
- R4: The save sequence takes NREG+2 cycles and writes one slot per cycle in ascending order. Slots 0 to NREG-1 hold registers 0 to NREG-1, slot NREG holds `core_pc_i`, and slot NREG+1 holds the active base.
- R5: On the cycle after the last save write, `in_mgmt_o` is 1 and `pc_load_o` pulses for one cycle with `pc_value_o` equal to base + 0x8000.
- R6: `resume_i` acts only in management mode while not busy, and is ignored otherwise. It reads the slots back in ascending order. Each register k appears once on `restore_we_o`/`restore_idx_o`/`restore_data_o` with its saved value. NREG+3 cycles after the cycle in which `resume_i` is sampled, `in_mgmt_o` is 0 and `pc_load_o` pulses with the saved program counter.
- R7: An ordinary (non-debug) access to the protected memory is granted only in management mode while not busy. When an access is refused, `mem_ok_o` is 0, `mem_rdata_o` is 0 and a write leaves memory unchanged. `mem_ok_o`/`mem_rdata_o` answer one cycle after the request.
- R8: A debug access (`mem_dbg_i`=1) is also granted in normal mode while the lock is clear. After one `lock_set_i` pulse, the lock stays set until reset and debug accesses outside management mode are refused.
- R9: The base resets to 0x30000. A write to slot NREG+1 during management mode changes neither the current mode nor the return address. It takes effect when the next resume reloads it, and so sets the entry address of the following entry.
- R10: A management request that arrives while in management mode stays pending. It is taken at the first boundary after the resume completes.
- R11: `busy_o` is 1 for the whole save or restore sequence, and `fetch_en_o` is 0 whenever `busy_o` is 1. `irq_ack_o` is 0 while busy or in management mode.
- R12: After reset `in_mgmt_o`, `busy_o`, `pc_load_o`, `irq_ack_o` and `mem_ok_o` are 0, and `fetch_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_req_i | input | 1 | Management request pulse |
| irq_req_i | input | NIRQ | Ordinary interrupt request lines |
| irq_mask_i | input | NIRQ | Software mask for ordinary lines, 1 = masked |
| irq_ack_o | output | NIRQ | One-hot acknowledge of the ordinary line taken |
| insn_done_i | input | 1 | Current instruction retired (boundary) |
| core_regs_i | input | NREG*W | Core register file, register k at bits k*W +: W |
| core_pc_i | input | W | Return program counter offered by the core |
| fetch_en_o | output | 1 | Instruction fetch allowed |
| busy_o | output | 1 | Save or restore sequence in progress |
| in_mgmt_o | output | 1 | Management mode flag |
| pc_load_o | output | 1 | One-cycle program counter redirect strobe |
| pc_value_o | output | W | Redirect target |
| restore_we_o | output | 1 | Restore write strobe to the register file |
| restore_idx_o | output | AW | Register index being restored |
| restore_data_o | output | W | Restored register value |
| resume_i | input | 1 | Resume command from the handler |
| lock_set_i | input | 1 | Sets the sticky protection lock |
| mem_req_i | input | 1 | Protected memory access request |
| mem_we_i | input | 1 | Write enable for the access |
| mem_dbg_i | input | 1 | Access arrives on the debug path |
| mem_addr_i | input | AW | Word address in the protected memory |
| mem_wdata_i | input | W | Write data |
| mem_ok_o | output | 1 | Access granted (one cycle after the request) |
| mem_rdata_o | output | W | Read data, 0 when refused |

## Verification
Some properties are checked by assertions on every cycle. These are: ordinary acknowledges are one-hot and suppressed at a boundary that takes the management request, a pending request is never dropped before it is taken, busy starts only after a boundary, the entry and exit redirect strobes coincide with the flag edges, restore writes occur only while busy, and the lock never clears while every granted access had the right to be granted. Other behaviour needs the bench's scenarios. That covers the contents and order of the save area, the values handed back by a restore after the core's registers were overwritten, the deferred effect of a base write, the queued request during management mode, and refused writes leaving memory intact.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_MGMT,
    ST_RESTORE,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/mgmt_req_arb.sv
module mgmt_req_arb #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mgmt_req_i,
  input  logic [NIRQ-1:0] irq_req_i,
  input  logic [NIRQ-1:0] irq_mask_i,
  input  logic            boundary_i,
  input  logic            idle_i,
  output logic            take_o,
  output logic [NIRQ-1:0] ack_o
);
  logic            pend_q;
  logic [NIRQ-1:0] ack_q;
  logic [NIRQ-1:0] live;
  logic [NIRQ-1:0] pick;
  logic            found;

  // the management request has no mask term at all
  assign take_o = boundary_i & idle_i & pend_q;
  assign live   = irq_req_i & ~irq_mask_i;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      if (live[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_o) | mgmt_req_i;
      if (boundary_i && idle_i && !pend_q) ack_q <= pick;
      else                                 ack_q <= '0;
    end
  end

  assign ack_o = ack_q;

  a_ack_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_q));
  a_mgmt_first_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (ack_q == '0));
  a_pend_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !take_o) |=> pend_q);
endmodule

// File: rtl/mgmt_save_ram.sv
module mgmt_save_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] q_q;

  // single port, read-first, registered output: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    q_q <= mem[addr_i];
  end

  assign q_o = q_q;
endmodule

// File: rtl/mgmt_access_guard.sv
module mgmt_access_guard (
  input  logic clk,
  input  logic rst,
  input  logic lock_set_i,
  input  logic req_i,
  input  logic dbg_i,
  input  logic in_mgmt_i,
  input  logic busy_i,
  output logic allow_o,
  output logic ok_o
);
  logic lock_q;
  logic ok_q;

  assign allow_o = req_i & ~busy_i & (in_mgmt_i | (dbg_i & ~lock_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      lock_q <= lock_q | lock_set_i;
      ok_q   <= allow_o;
    end
  end

  assign ok_o = ok_q;

  a_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_grant_right_R7: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> $past(in_mgmt_i || (dbg_i && !lock_q)));
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_pkg::*;
#(
  parameter int          W          = 32,
  parameter int          NREG       = 8,
  parameter int          AW         = 4,
  parameter logic [31:0] BASE_RESET = 32'h0003_0000,
  parameter logic [31:0] ENTRY_OFS  = 32'h0000_8000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take_i,
  input  logic                      resume_i,
  input  logic [NREG-1:0][W-1:0]    regs_i,
  input  logic [W-1:0]              pc_i,
  input  logic [W-1:0]              ram_q_i,
  output logic                      ram_we_o,
  output logic [AW-1:0]             ram_addr_o,
  output logic [W-1:0]              ram_wdata_o,
  output logic                      idle_o,
  output logic                      busy_o,
  output logic                      in_mgmt_o,
  output logic                      pc_load_o,
  output logic [W-1:0]              pc_val_o,
  output logic                      restore_we_o,
  output logic [AW-1:0]             restore_idx_o,
  output logic [W-1:0]              restore_data_o
);
  localparam int            NSLOT     = NREG + 2;
  localparam int            PC_SLOT   = NREG;
  localparam int            RW        = $clog2(NREG);
  localparam logic [AW-1:0] LAST      = AW'(NSLOT - 1);
  localparam logic [AW-1:0] PC_IDX    = AW'(PC_SLOT);

  seq_state_e    state_q;
  logic [AW-1:0] idx_q;
  logic          in_mgmt_q;
  logic          pc_load_q;
  logic [W-1:0]  pc_val_q;
  logic [W-1:0]  base_q;
  logic [W-1:0]  ret_pc_q;
  logic          rd_valid_q;
  logic [AW-1:0] rd_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      in_mgmt_q  <= 1'b0;
      pc_load_q  <= 1'b0;
      pc_val_q   <= '0;
      base_q     <= W'(BASE_RESET);
      ret_pc_q   <= '0;
      rd_valid_q <= 1'b0;
      rd_idx_q   <= '0;
    end else begin
      pc_load_q  <= 1'b0;
      rd_valid_q <= (state_q == ST_RESTORE);
      rd_idx_q   <= idx_q;
      if (rd_valid_q && rd_idx_q == PC_IDX) ret_pc_q <= ram_q_i;
      case (state_q)
        ST_IDLE: begin
          if (take_i) begin
            state_q <= ST_SAVE;
            idx_q   <= '0;
          end
        end
        ST_SAVE: begin
          if (idx_q == LAST) begin
            state_q   <= ST_MGMT;
            in_mgmt_q <= 1'b1;
            pc_load_q <= 1'b1;
            pc_val_q  <= base_q + W'(ENTRY_OFS);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_MGMT: begin
          if (resume_i) begin
            state_q <= ST_RESTORE;
            idx_q   <= '0;
          end
        end
        ST_RESTORE: begin
          if (idx_q == LAST) state_q <= ST_DRAIN;
          else               idx_q   <= idx_q + 1'b1;
        end
        ST_DRAIN: begin
          // the base slot is on the RAM output in this cycle
          state_q   <= ST_IDLE;
          in_mgmt_q <= 1'b0;
          pc_load_q <= 1'b1;
          pc_val_q  <= ret_pc_q;
          base_q    <= ram_q_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (int'(idx_q) < NREG)     ram_wdata_o = regs_i[idx_q[RW-1:0]];
    else if (idx_q == PC_IDX)   ram_wdata_o = pc_i;
    else                        ram_wdata_o = base_q;
  end

  assign ram_we_o       = (state_q == ST_SAVE);
  assign ram_addr_o     = idx_q;
  assign idle_o         = (state_q == ST_IDLE);
  assign busy_o         = (state_q == ST_SAVE) || (state_q == ST_RESTORE) ||
                          (state_q == ST_DRAIN);
  assign in_mgmt_o      = in_mgmt_q;
  assign pc_load_o      = pc_load_q;
  assign pc_val_o       = pc_val_q;
  assign restore_we_o   = rd_valid_q && (int'(rd_idx_q) < NREG);
  assign restore_idx_o  = rd_idx_q;
  assign restore_data_o = restore_we_o ? ram_q_i : '0;

  a_entry_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(in_mgmt_q) |-> (pc_load_q && pc_val_q == base_q + W'(ENTRY_OFS)));
  a_exit_redirect_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(in_mgmt_q) |-> (pc_load_q && state_q == ST_IDLE));
  a_restore_busy_R11: assert property (@(posedge clk) disable iff (rst)
    restore_we_o |-> (busy_o && in_mgmt_q));
endmodule

// File: rtl/mgmt_entry_seq.sv
module mgmt_entry_seq #(
  parameter int          W          = 32,
  parameter int          NREG       = 8,
  parameter int          DEPTH      = 16,
  parameter int          NIRQ       = 4,
  parameter logic [31:0] BASE_RESET = 32'h0003_0000,
  parameter logic [31:0] ENTRY_OFS  = 32'h0000_8000,
  parameter int          AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mgmt_req_i,
  input  logic [NIRQ-1:0]   irq_req_i,
  input  logic [NIRQ-1:0]   irq_mask_i,
  output logic [NIRQ-1:0]   irq_ack_o,
  input  logic              insn_done_i,
  input  logic [NREG*W-1:0] core_regs_i,
  input  logic [W-1:0]      core_pc_i,
  output logic              fetch_en_o,
  output logic              busy_o,
  output logic              in_mgmt_o,
  output logic              pc_load_o,
  output logic [W-1:0]      pc_value_o,
  output logic              restore_we_o,
  output logic [AW-1:0]     restore_idx_o,
  output logic [W-1:0]      restore_data_o,
  input  logic              resume_i,
  input  logic              lock_set_i,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic              mem_dbg_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [W-1:0]      mem_wdata_i,
  output logic              mem_ok_o,
  output logic [W-1:0]      mem_rdata_o
);
  logic                   take;
  logic                   idle;
  logic                   busy;
  logic                   in_mgmt;
  logic                   allow;
  logic                   seq_we;
  logic [AW-1:0]          seq_addr;
  logic [W-1:0]           seq_wdata;
  logic                   ram_we;
  logic [AW-1:0]          ram_addr;
  logic [W-1:0]           ram_wdata;
  logic [W-1:0]           ram_q;
  logic [NREG-1:0][W-1:0] regs_vec;

  assign regs_vec = core_regs_i;

  mgmt_req_arb #(.NIRQ(NIRQ)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .mgmt_req_i (mgmt_req_i),
    .irq_req_i  (irq_req_i),
    .irq_mask_i (irq_mask_i),
    .boundary_i (insn_done_i),
    .idle_i     (idle),
    .take_o     (take),
    .ack_o      (irq_ack_o)
  );

  mgmt_seq #(
    .W(W), .NREG(NREG), .AW(AW), .BASE_RESET(BASE_RESET), .ENTRY_OFS(ENTRY_OFS)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .take_i         (take),
    .resume_i       (resume_i),
    .regs_i         (regs_vec),
    .pc_i           (core_pc_i),
    .ram_q_i        (ram_q),
    .ram_we_o       (seq_we),
    .ram_addr_o     (seq_addr),
    .ram_wdata_o    (seq_wdata),
    .idle_o         (idle),
    .busy_o         (busy),
    .in_mgmt_o      (in_mgmt),
    .pc_load_o      (pc_load_o),
    .pc_val_o       (pc_value_o),
    .restore_we_o   (restore_we_o),
    .restore_idx_o  (restore_idx_o),
    .restore_data_o (restore_data_o)
  );

  mgmt_access_guard u_guard (
    .clk        (clk),
    .rst        (rst),
    .lock_set_i (lock_set_i),
    .req_i      (mem_req_i),
    .dbg_i      (mem_dbg_i),
    .in_mgmt_i  (in_mgmt),
    .busy_i     (busy),
    .allow_o    (allow),
    .ok_o       (mem_ok_o)
  );

  // the sequencer owns the memory port for the whole save/restore
  assign ram_we    = busy ? seq_we    : (allow & mem_we_i);
  assign ram_addr  = busy ? seq_addr  : mem_addr_i;
  assign ram_wdata = busy ? seq_wdata : mem_wdata_i;

  mgmt_save_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .q_o     (ram_q)
  );

  assign mem_rdata_o = mem_ok_o ? ram_q : '0;
  assign busy_o      = busy;
  assign in_mgmt_o   = in_mgmt;
  assign fetch_en_o  = ~busy;

  a_boundary_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !$past(busy_o) && !in_mgmt_o) |-> $past(insn_done_i));
  a_no_ack_in_mgmt_R11: assert property (@(posedge clk) disable iff (rst)
    (in_mgmt_o || busy_o) |-> (irq_ack_o == '0));
endmodule

// File: tb/tb_mgmt_entry_seq.sv
module tb_mgmt_entry_seq;
  localparam int          W      = 32;
  localparam int          NREG   = 8;
  localparam int          DEPTH  = 16;
  localparam int          NIRQ   = 4;
  localparam int          AW     = 4;
  localparam int          NSLOT  = NREG + 2;
  localparam logic [31:0] OFS    = 32'h0000_8000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mgmt_req_i = 0, insn_done_i = 0, resume_i = 0, lock_set_i = 0;
  logic [NIRQ-1:0]   irq_req_i = '0, irq_mask_i = '0, irq_ack_o;
  logic [NREG*W-1:0] core_regs_i;
  logic [W-1:0]      core_pc_i = '0;
  logic              fetch_en_o, busy_o, in_mgmt_o, pc_load_o, restore_we_o;
  logic [W-1:0]      pc_value_o, restore_data_o, mem_rdata_o;
  logic [AW-1:0]     restore_idx_o;
  logic              mem_req_i = 0, mem_we_i = 0, mem_dbg_i = 0, mem_ok_o;
  logic [AW-1:0]     mem_addr_i = '0;
  logic [W-1:0]      mem_wdata_i = '0;

  logic [W-1:0] regs  [NREG];
  logic [W-1:0] saved [NREG];
  logic [W-1:0] rest_val [NREG];
  logic [W-1:0] saved_pc, base_m, base_next;
  int n_chk = 0, n_fail = 0, mon_fail = 0;
  int busy_cnt = 0, rest_cnt = 0, pcl_cnt = 0;
  logic [W-1:0] pcl_val;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb
    for (int k = 0; k < NREG; k++) core_regs_i[k*W +: W] = regs[k];

  mgmt_entry_seq dut (.*);

  always @(negedge clk) if (!rst) begin
    if (busy_o) busy_cnt++;
    if (busy_o && fetch_en_o) begin
      mon_fail++; $display("FAIL R11 fetch_en act=1 exp=0 while busy");
    end
    if (irq_ack_o != 0 && (busy_o || in_mgmt_o)) begin
      mon_fail++; $display("FAIL R11 irq_ack act=%h exp=0", irq_ack_o);
    end
    if (pc_load_o) begin pcl_cnt++; pcl_val = pc_value_o; end
    if (restore_we_o) begin rest_cnt++; rest_val[restore_idx_o[2:0]] = restore_data_o; end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NIRQ-1:0] lowest(logic [NIRQ-1:0] v);
    for (int i = 0; i < NIRQ; i++) if (v[i]) return NIRQ'(1) << i;
    return '0;
  endfunction

  task automatic mem_op(bit we, bit dbg, int addr, logic [W-1:0] wd,
                        output logic ok, output logic [W-1:0] rd);
    mem_req_i = 1; mem_we_i = we; mem_dbg_i = dbg;
    mem_addr_i = AW'(addr); mem_wdata_i = wd;
    step();
    ok = mem_ok_o; rd = mem_rdata_o;
    mem_req_i = 0; mem_we_i = 0; mem_dbg_i = 0;
  endtask

  task automatic randomize_core();
    for (int k = 0; k < NREG; k++) regs[k] = $urandom;
    core_pc_i = $urandom;
  endtask

  task automatic pulse_req();
    mgmt_req_i = 1; step(); mgmt_req_i = 0;
  endtask

  // boundary with a request already pending; all ordinary lines raised
  task automatic do_entry(logic [NIRQ-1:0] mask);
    for (int k = 0; k < NREG; k++) saved[k] = regs[k];
    saved_pc = core_pc_i; base_next = base_m;
    busy_cnt = 0; pcl_cnt = 0;
    irq_req_i = '1; irq_mask_i = mask; insn_done_i = 1;
    step();
    insn_done_i = 0; irq_req_i = '0; irq_mask_i = '0;
    check("R2 ack suppressed by management request", W'(irq_ack_o), 0);
    check("R3 busy after boundary", W'(busy_o), 1);
    repeat (NSLOT) step();
    check("R4 save length", W'(busy_cnt), W'(NSLOT));
    check("R5 in_mgmt set", W'(in_mgmt_o), 1);
    check("R5 entry redirect", pc_load_o ? pc_value_o : 'x, base_m + OFS);
    step();
    check("R5 redirect one cycle", W'(pc_load_o), 0);
  endtask

  task automatic do_resume();
    for (int k = 0; k < NREG; k++) regs[k] = ~saved[k];
    for (int k = 0; k < NREG; k++) rest_val[k] = 'x;
    busy_cnt = 0; rest_cnt = 0;
    resume_i = 1; step(); resume_i = 0;
    repeat (NSLOT + 1) step();
    check("R6 restore busy length", W'(busy_cnt), W'(NSLOT + 1));
    check("R6 restore writes", W'(rest_cnt), W'(NREG));
    for (int k = 0; k < NREG; k++) check("R6 restored value", rest_val[k], saved[k]);
    check("R6 in_mgmt cleared", W'(in_mgmt_o), 0);
    check("R6 return redirect", pc_load_o ? pc_value_o : 'x, saved_pc);
    for (int k = 0; k < NREG; k++) regs[k] = saved[k];
    base_m = base_next;
    step();
  endtask

  initial begin
    logic ok;
    logic [W-1:0] rd;
    void'($urandom(32'd5150));
    base_m = 32'h0003_0000;
    for (int k = 0; k < NREG; k++) regs[k] = '0;
    repeat (3) step();
    rst = 0;
    step();
    // R12 reset state
    check("R12 in_mgmt", W'(in_mgmt_o), 0);
    check("R12 busy", W'(busy_o), 0);
    check("R12 fetch_en", W'(fetch_en_o), 1);
    check("R12 pc_load", W'(pc_load_o), 0);
    check("R12 irq_ack", W'(irq_ack_o), 0);
    check("R12 mem_ok", W'(mem_ok_o), 0);

    // R6 resume outside management mode is ignored
    rest_cnt = 0; busy_cnt = 0;
    resume_i = 1; step(); resume_i = 0; step(); step();
    check("R6 resume ignored busy", W'(busy_cnt), 0);
    check("R6 resume ignored restores", W'(rest_cnt), 0);

    // R3 no boundary, no entry; R1 every ordinary mask set
    randomize_core();
    pulse_req();
    busy_cnt = 0;
    repeat (4) step();
    check("R3 waits for boundary", W'(busy_cnt), 0);
    do_entry('1);
    check("R1 entered with all masks set", W'(in_mgmt_o), 1);

    // R4 save area contents, R9 reset base in its slot, R7 granted in mode
    for (int k = 0; k < NSLOT; k++) begin
      mem_op(0, 0, k, 0, ok, rd);
      check("R7 grant in management mode", W'(ok), 1);
      if (k < NREG)       check("R4 register slot", rd, saved[k]);
      else if (k == NREG) check("R4 pc slot", rd, saved_pc);
      else                check("R9 base slot at reset value", rd, 32'h0003_0000);
    end

    // R9 new base, R10 request queued in mode
    base_next = 32'h0005_0000;
    mem_op(1, 0, NREG + 1, base_next, ok, rd);
    pulse_req();
    insn_done_i = 1; step(); step(); insn_done_i = 0;
    check("R10 no re-entry while in mode", W'(busy_o), 0);
    check("R10 still in mode", W'(in_mgmt_o), 1);
    do_resume();
    busy_cnt = 0;
    repeat (2) step();
    check("R10 pending waits for boundary", W'(busy_cnt), 0);
    randomize_core();
    do_entry('0);
    check("R9 new base used", pcl_val, 32'h0005_8000);
    do_resume();

    // R7 normal mode plain access refused; R8 debug access before lock
    mem_op(0, 0, 0, 0, ok, rd);
    check("R7 plain read refused ok", W'(ok), 0);
    check("R7 plain read refused data", rd, 0);
    mem_op(1, 0, 0, 32'hDEAD_BEEF, ok, rd);
    mem_op(0, 1, 0, 0, ok, rd);
    check("R8 debug granted unlocked", W'(ok), 1);
    check("R7 refused write left slot", rd, saved[0]);

    // R2 ordinary interrupt priority
    for (int t = 0; t < 16; t++) begin
      logic [NIRQ-1:0] rq, mk;
      rq = NIRQ'($urandom); mk = NIRQ'($urandom);
      irq_req_i = rq; irq_mask_i = mk; insn_done_i = 1;
      step();
      insn_done_i = 0; irq_req_i = '0; irq_mask_i = '0;
      check("R2 lowest unmasked ack", W'(irq_ack_o), W'(lowest(rq & ~mk)));
      step();
    end

    // random entries with random base changes
    for (int t = 0; t < 5; t++) begin
      int s;
      randomize_core();
      pulse_req();
      do_entry(NIRQ'($urandom));
      s = $urandom_range(NREG - 1);
      mem_op(0, 0, s, 0, ok, rd);
      check("R4 random slot", rd, saved[s]);
      if ($urandom_range(1) == 1) begin
        base_next = {12'h000, 4'($urandom), 16'h0000};
        mem_op(1, 0, NREG + 1, base_next, ok, rd);
      end
      do_resume();
    end

    // R8 lock
    lock_set_i = 1; step(); lock_set_i = 0;
    repeat (3) step();
    mem_op(0, 1, 1, 0, ok, rd);
    check("R8 debug refused after lock", W'(ok), 0);
    check("R8 debug data after lock", rd, 0);
    randomize_core();
    pulse_req();
    do_entry('0);
    mem_op(0, 0, 1, 0, ok, rd);
    check("R7 granted in mode after lock", rd, saved[1]);
    do_resume();
    mem_op(0, 1, 1, 0, ok, rd);
    check("R8 lock persists", W'(ok), 0);

    check("R11 monitor", W'(mon_fail), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule